// File: doc/BRIEF.md
# Serial Flash Sequential Read Engine

This block is the slave-side read path of a serial flash device. After chip select is pulled low it collects a command byte and a 24-bit start address from the serial input. When the command is the read code, it streams bytes from the storage array out on the serial output, most significant bit first, for as long as chip select stays low. It needs no further command between bytes, and the address rolls over to zero after the last location.

The engine runs on a fast system clock. The serial clock, chip select and serial input are treated as slow pins. They pass through a synchronizer whose length is set by a parameter, and the engine acts on their edges. Array bytes come from a simple registered memory port: the engine raises a one-cycle read strobe with a byte address and takes the data one system clock later. The next byte is always fetched while the current one is still shifting out. A busy flag from the write/erase logic makes the engine reject the whole transaction without touching the memory. The serial output comes with a separate enable for the pad driver.

Top module: `sfr_read_engine`

## Requirements
- R1: After reset, and while chip select is high, `so_oe` is 0 and `mem_rd` is 0.
- R2: Command and address bits are taken on rising serial clock edges, MSB first: 8 command bits, then 24 address bits starting with bit 23. The command code 03h (parameter `READ_CODE`) starts a read at the received address.
- R3: `so_oe` stays 0 throughout the command and address phases.
- R4: Data bits are driven on falling serial clock edges, MSB first. The first bit goes out on the falling edge after the 32nd rising edge, and `so_oe` rises at that edge.
- R5: After each byte the address advances by one, and the next byte follows with no gap. Every byte the master clocks matches the array content at its address.
- R6: The address counter is `ADDR_W` bits wide. Received address bits at or above `ADDR_W` are ignored, and after the highest address (2^ADDR_W - 1) the output continues from address 0.
- R7: Raising chip select at any point ends the command. `so_oe` falls in the same instant, with no clock needed. A new transaction then starts cleanly from its command byte.
- R8: If `busy` is 1 when the eighth command bit is taken, the transaction is ignored: no `mem_rd` pulse is issued and `so_oe` stays 0 until chip select rises.
- R9: A command code other than `READ_CODE` leaves the engine idle until chip select rises: no `mem_rd` pulse and `so_oe` stays 0.
- R10: Exactly one `mem_rd` pulse is issued when the address completes, and one more at the start of each data byte. `mem_rdata` is taken one system clock after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data input |
| busy | input | 1 | A write, program or erase cycle is running |
| so | output | 1 | Serial data output value |
| so_oe | output | 1 | Output enable for the serial output pad |
| mem_rd | output | 1 | One-cycle array read strobe |
| mem_addr | output | ADDR_W | Byte address of the array read |
| mem_rdata | input | 8 | Array byte, valid one clock after `mem_rd` |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock. Each serial clock phase must last several system clocks, so that an edge can pass the synchronizer and a prefetch can finish before the next falling edge. They also assume that `busy` is steady around the moment the command byte completes. The stimulus holds every serial clock phase for eight system clocks and changes the serial pins only on the falling system clock. It sets `busy` only between transactions and raises chip select only while the serial clock is high.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   localparam int CMD_BITS   = 8;
   localparam int FIELD_BITS = 24;
   localparam int HDR_BITS   = CMD_BITS + FIELD_BITS;
   localparam int HDR_CNT_W  = $clog2(HDR_BITS);
   localparam int BYTE_W     = 8;
   localparam int BIT_IDX_W  = $clog2(BYTE_W);

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CMD,
      PH_ADDR,
      PH_DATA,
      PH_IGNORE
   } phase_t;
endpackage

// File: rtl/sfr_pin_sync.sv
module sfr_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("sfr_pin_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign lvl = din;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= {STAGES{RST_VAL}};
            end else begin
               chain[0] <= din;
               for (int i = 1; i < STAGES; i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign lvl = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sfr_hdr_rx.sv
module sfr_hdr_rx
   import sfr_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                shift_en,
   input  logic                si,
   output logic                cmd_done,
   output logic                hdr_done,
   output logic [CMD_BITS-1:0] cmd_byte,
   output logic [ADDR_W-1:0]   start_addr
);
   logic [HDR_CNT_W-1:0]  cnt;
   logic [FIELD_BITS-2:0] sr;
   logic [FIELD_BITS-1:0] field;

   assign cmd_done   = shift_en && (cnt == HDR_CNT_W'(CMD_BITS - 1));
   assign hdr_done   = shift_en && (cnt == HDR_CNT_W'(HDR_BITS - 1));
   assign cmd_byte   = {sr[CMD_BITS-2:0], si};
   assign field      = {sr, si};
   assign start_addr = field[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sr  <= '0;
      end else if (clr) begin
         cnt <= '0;
         sr  <= '0;
      end else if (shift_en) begin
         cnt <= cnt + 1'b1;
         sr  <= {sr[FIELD_BITS-3:0], si};
      end
   end
endmodule

// File: rtl/sfr_addr_ctr.sv
module sfr_addr_ctr #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr
);
   logic [ADDR_W-1:0] addr_q;
   logic              rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rd_q   <= 1'b0;
      end else begin
         rd_q <= load | step;
         if (load) begin
            addr_q <= load_addr;
         end else if (step) begin
            addr_q <= addr_q + 1'b1;
         end
      end
   end

   assign mem_rd   = rd_q;
   assign mem_addr = addr_q;
endmodule

// File: rtl/sfr_byte_tx.sv
module sfr_byte_tx
   import sfr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fall_en,
   input  logic              mem_rd,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              byte_start,
   output logic              so_bit,
   output logic              drive
);
   logic                 rd_q;
   logic [BYTE_W-1:0]    nbuf;
   logic [BYTE_W-2:0]    shreg;
   logic [BIT_IDX_W-1:0] bcnt;
   logic                 so_q;
   logic                 drv_q;

   assign byte_start = fall_en && (bcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b0;
         nbuf <= '0;
      end else begin
         rd_q <= mem_rd;
         if (rd_q) begin
            nbuf <= mem_rdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt  <= '0;
         shreg <= '0;
         so_q  <= 1'b0;
         drv_q <= 1'b0;
      end else if (clr) begin
         bcnt  <= '0;
         shreg <= '0;
         so_q  <= 1'b0;
         drv_q <= 1'b0;
      end else if (fall_en) begin
         drv_q <= 1'b1;
         bcnt  <= bcnt + 1'b1;
         if (bcnt == '0) begin
            {so_q, shreg} <= nbuf;
         end else begin
            {so_q, shreg} <= {shreg, 1'b0};
         end
      end
   end

   assign so_bit = so_q;
   assign drive  = drv_q;
endmodule

// File: rtl/sfr_read_engine.sv
module sfr_read_engine
   import sfr_pkg::*;
#(
   parameter int          ADDR_W      = 24,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  READ_CODE   = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   input  logic              busy,
   output logic              so,
   output logic              so_oe,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [BYTE_W-1:0] mem_rdata
);
   generate
      if (ADDR_W < 1 || ADDR_W > FIELD_BITS) begin : g_bad_addr
         $error("sfr_read_engine: ADDR_W must be 1..24");
      end
   endgenerate

   logic cs_s, sck_s, si_s, sck_p;
   logic sck_rise, sck_fall;
   phase_t ph;

   sfr_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .din(cs_n), .lvl(cs_s));
   sfr_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .din(sck), .lvl(sck_s));
   sfr_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_si_sync (
      .clk(clk), .rst_n(rst_n), .din(si), .lvl(si_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_p <= 1'b0;
      else        sck_p <= sck_s;
   end

   assign sck_rise = sck_s & ~sck_p;
   assign sck_fall = ~sck_s & sck_p;

   logic                shift_en, cmd_done, hdr_done;
   logic [CMD_BITS-1:0] cmd_byte;
   logic [ADDR_W-1:0]   start_addr;

   assign shift_en = sck_rise && !cs_s && (ph == PH_CMD || ph == PH_ADDR);

   sfr_hdr_rx #(.ADDR_W(ADDR_W)) u_hdr (
      .clk(clk), .rst_n(rst_n), .clr(ph == PH_IDLE), .shift_en(shift_en),
      .si(si_s), .cmd_done(cmd_done), .hdr_done(hdr_done),
      .cmd_byte(cmd_byte), .start_addr(start_addr));

   logic fall_en, byte_start, so_bit, drive;
   logic load;

   assign fall_en = sck_fall && !cs_s && (ph == PH_DATA);
   assign load    = hdr_done && (ph == PH_ADDR);

   sfr_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(load), .load_addr(start_addr),
      .step(byte_start), .mem_rd(mem_rd), .mem_addr(mem_addr));

   sfr_byte_tx u_tx (
      .clk(clk), .rst_n(rst_n), .clr(ph != PH_DATA), .fall_en(fall_en),
      .mem_rd(mem_rd), .mem_rdata(mem_rdata), .byte_start(byte_start),
      .so_bit(so_bit), .drive(drive));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph <= PH_IDLE;
      end else if (cs_s) begin
         ph <= PH_IDLE;
      end else begin
         case (ph)
            PH_IDLE: ph <= PH_CMD;
            PH_CMD: begin
               if (cmd_done) begin
                  ph <= (busy || cmd_byte != READ_CODE) ? PH_IGNORE : PH_ADDR;
               end
            end
            PH_ADDR: begin
               if (hdr_done) ph <= PH_DATA;
            end
            default: ph <= ph;
         endcase
      end
   end

   assign so    = so_bit;
   assign so_oe = drive & ~cs_n;
endmodule

// File: rtl/sfr_read_chk.sv
module sfr_read_chk
   import sfr_pkg::*;
#(
   parameter int         ADDR_W    = 24,
   parameter logic [7:0] READ_CODE = 8'h03
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_n,
   input logic                cs_s,
   input logic                busy,
   input logic                so,
   input logic                so_oe,
   input logic                mem_rd,
   input logic [ADDR_W-1:0]   mem_addr,
   input phase_t              ph,
   input logic                cmd_done,
   input logic [CMD_BITS-1:0] cmd_byte,
   input logic                sck_fall
);
   logic              have_prev;
   logic [ADDR_W-1:0] prev_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_addr <= '0;
      end else if (ph != PH_DATA) begin
         have_prev <= 1'b0;
      end else if (mem_rd) begin
         have_prev <= 1'b1;
         prev_addr <= mem_addr;
      end
   end

   AST_OE_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe |-> (ph == PH_DATA)); // R3

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && have_prev) |-> (mem_addr == ADDR_W'(prev_addr + 1'b1))); // R5

   AST_SO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && !sck_fall && !cs_s) |=> ($stable(so) || cs_n)); // R4

   AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_done && busy && !cs_s) |=> (ph == PH_IGNORE)); // R8

   AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_done && cmd_byte != READ_CODE && !cs_s) |=> (ph == PH_IGNORE)); // R9

   AST_NO_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IGNORE) |-> !mem_rd); // R8

   AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd); // R10

   AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE) |-> (!mem_rd && !so_oe)); // R1
endmodule

bind sfr_read_engine sfr_read_chk #(.ADDR_W(ADDR_W), .READ_CODE(READ_CODE)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_s(cs_s), .busy(busy), .so(so),
   .so_oe(so_oe), .mem_rd(mem_rd), .mem_addr(mem_addr), .ph(ph),
   .cmd_done(cmd_done), .cmd_byte(cmd_byte), .sck_fall(sck_fall));

// File: tb/test_sfr_read_engine.sv
`timescale 1ns/1ps
module test_sfr_read_engine;
   localparam int AW = 8;
   localparam int HP = 8;

   logic clk = 1'b0;
   logic rst_n, cs_n, sck, si, busy;
   logic so, so_oe, mem_rd;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_rdata;

   always #10 clk = ~clk;

   sfr_read_engine #(.ADDR_W(AW), .SYNC_STAGES(2), .READ_CODE(8'h03)) i_sfr_read_engine (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .busy(busy),
      .so(so), .so_oe(so_oe), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata));

   function automatic logic [7:0] arr(input logic [AW-1:0] a);
      logic [7:0] x;
      x = 8'(a);
      return 8'(x * 8'd37) ^ 8'hC3;
   endfunction

   always_ff @(posedge clk) begin
      if (mem_rd) mem_rdata <= arr(mem_addr);
   end

   int rd_count = 0;
   always @(posedge clk) begin
      if (rst_n === 1'b1 && mem_rd === 1'b1) rd_count++;
   end

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // scoreboard
   logic [7:0] exp_q[$];
   string      tag_q[$];
   int         mbits = 0;
   logic [7:0] mbyte = 8'h00;
   logic [7:0] mexp;
   string      mtag;

   always @(posedge sck) begin
      if (cs_n === 1'b0 && so_oe === 1'b1) begin
         mbyte = {mbyte[6:0], so};
         mbits++;
         if (mbits == 8) begin
            mbits = 0;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5", "unexpected byte", {24'h0, mbyte}, 32'h0);
            end else begin
               mexp = exp_q.pop_front();
               mtag = tag_q.pop_front();
               chk(mbyte === mexp, mtag, "data byte", {24'h0, mbyte}, {24'h0, mexp});
            end
         end
      end
   end

   always @(posedge cs_n) mbits = 0;

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hdr_bit(input logic b);
      sck = 1'b0;
      si  = b;
      wclk(HP);
      sck = 1'b1;
      wclk(1);
      chk(so_oe === 1'b0, "R3", "so_oe in header", {31'h0, so_oe}, 32'h0);
      wclk(HP - 1);
   endtask

   task automatic send_hdr(input logic [7:0] code, input logic [23:0] a);
      cs_n = 1'b0;
      wclk(HP);
      for (int i = 7; i >= 0; i--) hdr_bit(code[i]);
      for (int i = 23; i >= 0; i--) hdr_bit(a[i]);
   endtask

   task automatic data_clk(input bit hiz_chk, input string tag);
      sck = 1'b0;
      wclk(HP);
      sck = 1'b1;
      if (hiz_chk) chk(so_oe === 1'b0, tag, "so_oe ignored txn", {31'h0, so_oe}, 32'h0);
      wclk(HP);
   endtask

   task automatic end_txn();
      cs_n = 1'b1;
      #1;
      chk(so_oe === 1'b0, "R7", "so_oe at cs rise", {31'h0, so_oe}, 32'h0);
      wclk(HP);
      sck = 1'b0;
      wclk(4 * HP);
      chk(exp_q.size() == 0, "R5", "bytes left unread", exp_q.size(), 32'h0);
      exp_q.delete();
      tag_q.delete();
   endtask

   task automatic read_txn(input logic [23:0] a, input int n, input string tag);
      int start;
      logic [AW-1:0] base;
      start = rd_count;
      base  = a[AW-1:0];
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(arr(AW'(base + AW'(i))));
         tag_q.push_back(tag);
      end
      send_hdr(8'h03, a);
      for (int i = 0; i < n * 8; i++) data_clk(1'b0, tag);
      end_txn();
      chk(rd_count - start == n + 1, "R10", "strobe count", rd_count - start, n + 1);
   endtask

   task automatic ignored_txn(input logic [7:0] code, input string tag);
      int start;
      start = rd_count;
      send_hdr(code, 24'h000020);
      for (int i = 0; i < 16; i++) data_clk(1'b1, tag);
      end_txn();
      chk(rd_count == start, tag, "strobes in ignored txn", rd_count - start, 32'h0);
   endtask

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; busy = 1'b0;
      wclk(5);
      rst_n = 1'b1;
      wclk(5);
      chk(so_oe === 1'b0, "R1", "so_oe after reset", {31'h0, so_oe}, 32'h0);
      chk(mem_rd === 1'b0, "R1", "mem_rd after reset", {31'h0, mem_rd}, 32'h0);

      read_txn(24'h000010, 6, "R2");        // plain read, R4 R5 timing
      read_txn(24'h0000FE, 4, "R6");        // wrap FE FF 00 01
      read_txn(24'hABCD33, 2, "R6");        // upper bits dropped

      busy = 1'b1;
      ignored_txn(8'h03, "R8");
      busy = 1'b0;
      read_txn(24'h000005, 1, "R8");        // recovers once idle

      ignored_txn(8'h0B, "R9");
      read_txn(24'h000077, 1, "R9");

      // R7: abort in the middle of the second byte
      begin
         int start;
         start = rd_count;
         exp_q.push_back(arr(8'h40));
         tag_q.push_back("R7");
         send_hdr(8'h03, 24'h000040);
         for (int i = 0; i < 11; i++) data_clk(1'b0, "R7");
         end_txn();
         chk(rd_count - start == 3, "R7", "strobes after abort", rd_count - start, 32'd3);
      end
      read_txn(24'h000080, 2, "R7");

      chk(so_oe === 1'b0 && mem_rd === 1'b0, "R1", "quiet when deselected",
          {30'h0, so_oe, mem_rd}, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule